// File: doc/BRIEF.md
# Coprocessor Timer Interrupt Controller

This block holds the timer portion of a system-control coprocessor: a free-running 32-bit cycle counter, a 32-bit compare value, the status register and the cause register. Software reaches them through a single write port that names a register number and a select. The core's pipeline issues a count-enable strobe whenever the counter should advance.

When an increment brings the counter to the compare value, the block sets the timer pending flag. This flag is the most significant pending bit of the cause register. Writing the compare register acknowledges the timer and clears that flag. The other seven pending bits follow external hardware interrupt lines.

The block produces a single registered interrupt request, which is level-sensitive. The request is high only when all of the following hold: at least one pending bit meets a set mask bit, the global enable is set, and neither the exception level nor the error level is set.

Top module: `cp0_timer_irq`

## Requirements
- R1: When `cnt_step` is high and no count write occurs, `count_o` increases by exactly one at the next clock edge. The value 0xFFFF_FFFF wraps to 0.
- R2: Suppose an increment produces a new count equal to the current compare value. Then cause bit 15 reads 1 from the same clock edge on. The flag stays set until it is cleared as described in R4.
- R3: A write with `wr_reg`=9 and `wr_sel`=0 loads `count_o` from `wr_data[31:0]`. Such a write overrides a simultaneous `cnt_step`, so no increment happens that cycle. A count write by itself never sets cause bit 15.
- R4: A write with `wr_reg`=11 and `wr_sel`=0 loads `compare_o` from `wr_data[31:0]` and clears cause bit 15. The clear wins over a match in the same cycle.
- R5: A write with `wr_reg`=12 and `wr_sel`=0 loads the status register as follows. Bits 31:28 are the coprocessor-usable field. Bits 15:8 are the interrupt mask. Bit 2 is the error level, bit 1 the exception level and bit 0 the global enable. Every other status bit reads 0.
- R6: Cause bits 14:8 show `hw_irq[6:0]` one clock later. Cause bits 31:16 and 7:0 read 0.
- R7: `irq_o` is a register. One clock after the status and cause outputs show enable=1, exception level=0, error level=0 and a nonzero value for (cause[15:8] AND status[15:8]), it goes high. It stays high only while that condition holds.
- R8: While either the exception level or the error level is set, `irq_o` is low one clock later, whatever the pending and mask bits are.
- R9: A write with `wr_en` low, or with any register/select pair other than 9/0, 11/0 or 12/0, changes no output. Bits 63:32 of `wr_data` are ignored.
- R10: After a clock edge with `rst_n` low, count, compare, status, cause and `irq_o` all read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_step | input | 1 | Advance the counter by one this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_reg | input | 5 | Register number of the write |
| wr_sel | input | 3 | Select of the write |
| wr_data | input | 64 | Write data; only bits 31:0 are used |
| hw_irq | input | 7 | External interrupt lines, cause bits 14:8 |
| count_o | output | 32 | Counter value |
| compare_o | output | 32 | Compare value |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Writes, increments and the timer pending flag all show on the register outputs at the first clock edge after the stimulus. The sampled hardware lines also reach cause one edge later. `irq_o` comes one edge after that, because it is computed from registered status and cause. The bench drives each cycle's inputs at the falling edge and pushes the state it expects after the next rising edge. The monitor samples one nanosecond after that rising edge. In this way each expectation, including the extra cycle of interrupt latency, is compared in exactly the cycle it is due.

// File: rtl/cp0t_pkg.sv
// Package: shared constants, field positions and the write-target encoding
// for the coprocessor timer interrupt controller.
package cp0t_pkg;
    localparam int DATA_W     = 32;
    localparam int REG_W      = 5;
    localparam int SEL_W      = 3;
    localparam int IP_W       = 8;          // pending / mask field width
    localparam int IP_LO      = 8;          // lowest bit of pending / mask
    localparam int IP_HI      = IP_LO + IP_W - 1;
    localparam int HW_W       = IP_W - 1;   // external lines below timer bit
    localparam int CU_HI      = 31;
    localparam int CU_LO      = 28;
    localparam int IE_BIT     = 0;
    localparam int EXL_BIT    = 1;
    localparam int ERL_BIT    = 2;

    localparam logic [REG_W-1:0] REGNUM_COUNT   = 5'd9;
    localparam logic [REG_W-1:0] REGNUM_COMPARE = 5'd11;
    localparam logic [REG_W-1:0] REGNUM_STATUS  = 5'd12;

    typedef enum logic [1:0] {
        WT_NONE,
        WT_COUNT,
        WT_COMPARE,
        WT_STATUS
    } wr_target_e;

    // Bits of the status register that are implemented (all else reads 0).
    function automatic logic [DATA_W-1:0] status_keep_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        m[CU_HI:CU_LO] = '1;
        m[IP_HI:IP_LO] = '1;
        m[IE_BIT]      = 1'b1;
        m[EXL_BIT]     = 1'b1;
        m[ERL_BIT]     = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/cp0t_wr_decode.sv
// Module: cp0t_wr_decode
// Turns the register-number / select pair of a write into one target.
// Assumes select 0 is the only implemented select for every register.
module cp0t_wr_decode
    import cp0t_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_reg,
    input  logic [SEL_W-1:0] wr_sel,
    output wr_target_e       target
);
    // Purpose: pick the written register, or none.
    always_comb begin
        target = WT_NONE;
        if (wr_en && (wr_sel == '0)) begin
            unique case (wr_reg)
                REGNUM_COUNT:   target = WT_COUNT;
                REGNUM_COMPARE: target = WT_COMPARE;
                REGNUM_STATUS:  target = WT_STATUS;
                default:        target = WT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cp0t_counter.sv
// Module: cp0t_counter
// Free-running counter. A software load wins over an increment in the
// same cycle. Exposes the incremented value and whether it is applied,
// so the compare logic can match on the new count.
module cp0t_counter
    import cp0t_pkg::*;
#(
    parameter int W = DATA_W
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         inc_fire,
    output logic [W-1:0] inc_val
);
    // Purpose: the increment applies only when no load is present.
    assign inc_fire = step && !load;
    assign inc_val  = count + W'(1);

    // Purpose: hold the count register.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (load)     count <= load_val;
        else if (inc_fire) count <= inc_val;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (count == $past(count) + W'(1))); // R1
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val))); // R3
endmodule

// File: rtl/cp0t_compare.sv
// Module: cp0t_compare
// Compare register and timer pending flag. The flag is set when an applied
// increment lands on the compare value; a compare write clears it and has
// priority over a match in the same cycle.
module cp0t_compare
    import cp0t_pkg::*;
#(
    parameter int W = DATA_W
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc_fire,
    input  logic [W-1:0] inc_val,
    output logic [W-1:0] compare,
    output logic         pend
);
    logic hit;

    // Purpose: detect a match on the newly incremented count.
    assign hit = inc_fire && (inc_val == compare);

    // Purpose: hold the compare register.
    always_ff @(posedge clk) begin
        if (!rst_n)    compare <= '0;
        else if (load) compare <= load_val;
    end

    // Purpose: set and acknowledge the timer pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (load) pend <= 1'b0;
        else if (hit)  pend <= 1'b1;
    end

    AST_PEND_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !pend); // R4
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_fire && !load && (inc_val == compare)) |=> pend); // R2
    AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_fire && !load) |=> $stable(pend)); // R3
endmodule

// File: rtl/cp0t_status.sv
// Module: cp0t_status
// Status register: usable field, interrupt mask, error level, exception
// level and global enable. Unimplemented bits are dropped on write.
module cp0t_status
    import cp0t_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] status
);
    localparam logic [DATA_W-1:0] KEEP = status_keep_mask();

    // Purpose: load the implemented fields on a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)    status <= '0;
        else if (load) status <= load_val & KEEP;
    end

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(status)); // R9
    AST_STATUS_CU: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (status[CU_HI:CU_LO] == $past(load_val[CU_HI:CU_LO]))); // R5
endmodule

// File: rtl/cp0t_irq.sv
// Module: cp0t_irq
// Registered interrupt request. Needs enable, no exception or error level,
// and at least one pending bit under a set mask bit. Assumes its inputs
// come from registers, so the request trails them by one cycle.
module cp0t_irq
    import cp0t_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ie,
    input  logic            exl,
    input  logic            erl,
    input  logic [IP_W-1:0] mask,
    input  logic [IP_W-1:0] pending,
    output logic            irq
);
    logic want;

    // Purpose: combine the gating bits with any unmasked pending source.
    assign want = ie && !exl && !erl && ((pending & mask) != '0);

    // Purpose: register the level-sensitive request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= want;
    end

    AST_IRQ_LEVEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (exl || erl) |=> !irq); // R8
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |=> !irq); // R7
    AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending & mask) == '0) |=> !irq); // R7
endmodule

// File: rtl/cp0_timer_irq.sv
// Module: cp0_timer_irq (top)
// Timer counter, compare, status and cause registers of a system-control
// coprocessor plus the interrupt request they produce. Assumes one write
// per cycle and external interrupt lines synchronous to clk.
module cp0_timer_irq
    import cp0t_pkg::*;
#(
    parameter int WDATA_W = 64
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_step,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_reg,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic [HW_W-1:0]    hw_irq,
    output logic [DATA_W-1:0]  count_o,
    output logic [DATA_W-1:0]  compare_o,
    output logic [DATA_W-1:0]  status_o,
    output logic [DATA_W-1:0]  cause_o,
    output logic               irq_o
);
    wr_target_e        tgt;
    logic [DATA_W-1:0] wval;
    logic              inc_fire;
    logic [DATA_W-1:0] inc_val;
    logic              timer_pend;
    logic [HW_W-1:0]   hw_q;

    // Purpose: keep the low word of the write data.
    assign wval = wr_data[DATA_W-1:0];

    generate
        if (WDATA_W > DATA_W) begin : g_wide
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wr_data[WDATA_W-1:DATA_W];
        end
    endgenerate

    cp0t_wr_decode u_dec (
        .wr_en  (wr_en),
        .wr_reg (wr_reg),
        .wr_sel (wr_sel),
        .target (tgt)
    );

    cp0t_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (cnt_step),
        .load     (tgt == WT_COUNT),
        .load_val (wval),
        .count    (count_o),
        .inc_fire (inc_fire),
        .inc_val  (inc_val)
    );

    cp0t_compare #(.W(DATA_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tgt == WT_COMPARE),
        .load_val (wval),
        .inc_fire (inc_fire),
        .inc_val  (inc_val),
        .compare  (compare_o),
        .pend     (timer_pend)
    );

    cp0t_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tgt == WT_STATUS),
        .load_val (wval),
        .status   (status_o)
    );

    // Purpose: sample the external interrupt lines into cause.
    always_ff @(posedge clk) begin
        if (!rst_n) hw_q <= '0;
        else        hw_q <= hw_irq;
    end

    // Purpose: assemble the cause register; unused bits read zero.
    always_comb begin
        cause_o            = '0;
        cause_o[IP_HI]     = timer_pend;
        cause_o[IP_HI-1:IP_LO] = hw_q;
    end

    cp0t_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ie      (status_o[IE_BIT]),
        .exl     (status_o[EXL_BIT]),
        .erl     (status_o[ERL_BIT]),
        .mask    (status_o[IP_HI:IP_LO]),
        .pending (cause_o[IP_HI:IP_LO]),
        .irq     (irq_o)
    );

    AST_CAUSE_HW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cause_o[IP_HI-1:IP_LO] == $past(hw_irq))); // R6
    AST_CAUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o[DATA_W-1:IP_HI+1] == '0) && (cause_o[IP_LO-1:0] == '0)); // R6
endmodule

// File: tb/tb_cp0_timer_irq.sv
`timescale 1ns/1ps
module tb_cp0_timer_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_step = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_reg = '0;
    logic [2:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [6:0]  hw_irq = '0;
    logic [31:0] count_o, compare_o, status_o, cause_o;
    logic        irq_o;

    always #2 clk = ~clk;   // 250 MHz

    cp0_timer_irq dut (
        .clk(clk), .rst_n(rst_n), .cnt_step(cnt_step), .wr_en(wr_en),
        .wr_reg(wr_reg), .wr_sel(wr_sel), .wr_data(wr_data), .hw_irq(hw_irq),
        .count_o(count_o), .compare_o(compare_o), .status_o(status_o),
        .cause_o(cause_o), .irq_o(irq_o)
    );

    typedef struct {
        logic [31:0] cnt, cmp, sts, cau;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_cnt = '0, m_cmp = '0, m_sts = '0;
    logic        m_pend = 0, m_irq = 0;
    logic [6:0]  m_hw = '0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic cyc(logic st, logic we, logic [4:0] rg, logic [2:0] sl,
                       logic [63:0] d, logic [6:0] hw, string tag);
        logic wc, wk, ws, inc;
        logic [31:0] cau, n_cnt;
        exp_t e;
        @(negedge clk);
        cnt_step = st; wr_en = we; wr_reg = rg; wr_sel = sl; wr_data = d; hw_irq = hw;
        wc  = we && rg == 5'd9  && sl == 3'd0;
        wk  = we && rg == 5'd11 && sl == 3'd0;
        ws  = we && rg == 5'd12 && sl == 3'd0;
        inc = st && !wc;
        cau = {16'h0, m_pend, m_hw, 8'h0};
        m_irq = m_sts[0] && !m_sts[1] && !m_sts[2] && ((cau[15:8] & m_sts[15:8]) != 0);
        n_cnt = wc ? d[31:0] : (inc ? m_cnt + 1 : m_cnt);
        if (wk)                            m_pend = 0;
        else if (inc && m_cnt + 1 == m_cmp) m_pend = 1;
        if (wk) m_cmp = d[31:0];
        if (ws) m_sts = d[31:0] & 32'hF000_FF07;
        m_cnt = n_cnt;
        m_hw  = hw;
        e.cnt = m_cnt; e.cmp = m_cmp; e.sts = m_sts;
        e.cau = {16'h0, m_pend, m_hw, 8'h0}; e.irq = m_irq; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(string tag);
        cyc(0, 0, 5'd0, 3'd0, 64'h0, m_hw, tag);
    endtask

    task automatic wr(logic [4:0] rg, logic [31:0] v, string tag);
        cyc(0, 1, rg, 3'd0, {32'hDEAD_BEEF, v}, m_hw, tag);
    endtask

    // Monitor: samples 1 ns after each rising edge and checks the oldest item.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "count",   count_o,   e.cnt);
            chk(e.tag, "compare", compare_o, e.cmp);
            chk(e.tag, "status",  status_o,  e.sts);
            chk(e.tag, "cause",   cause_o,   e.cau);
            chk(e.tag, "irq",     {31'h0, irq_o}, {31'h0, e.irq});
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state after reset edges with junk on the inputs
        cnt_step = 1; hw_irq = 7'h7F;
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "count",   count_o,   0);
        chk("R10", "compare", compare_o, 0);
        chk("R10", "status",  status_o,  0);
        chk("R10", "cause",   cause_o,   0);
        chk("R10", "irq",     {31'h0, irq_o}, 0);
        @(negedge clk);
        rst_n = 1; cnt_step = 0; hw_irq = 0;

        // R5: status write keeps only implemented fields
        wr(5'd12, 32'hFFFF_FFFF, "R5");
        wr(5'd12, 32'h0000_8001, "R5");   // mask bit 15, enable
        // R1: plain increments
        repeat (3) cyc(1, 0, 0, 0, 0, 0, "R1");
        // R3: count load, then R4 compare load, then R2 match
        wr(5'd9, 32'd3, "R3");
        wr(5'd11, 32'd5, "R4");
        cyc(1, 0, 0, 0, 0, 0, "R1");
        cyc(1, 0, 0, 0, 0, 0, "R2");      // count becomes 5 -> pending
        idle("R7");                        // irq rises here
        idle("R7");
        wr(5'd12, 32'h0000_8003, "R8");   // exception level
        idle("R8");
        wr(5'd12, 32'h0000_8005, "R8");   // error level
        idle("R8");
        wr(5'd12, 32'h0000_8001, "R7");
        idle("R7");
        wr(5'd11, 32'd100, "R4");         // acknowledge
        idle("R4");
        idle("R7");
        // R3: count write wins over step, and never sets pending
        cyc(1, 1, 5'd9, 3'd0, 64'h1234_5678_0000_0063, 0, "R3");
        wr(5'd9, 32'd100, "R3");
        idle("R3");
        // R1/R2: wrap to zero matches compare of zero
        wr(5'd11, 32'd0, "R4");
        wr(5'd9, 32'hFFFF_FFFF, "R3");
        cyc(1, 0, 0, 0, 0, 0, "R1");
        idle("R2");
        // R4: compare write clears even when a match happens the same cycle
        wr(5'd11, 32'd10, "R4");
        wr(5'd9, 32'd9, "R3");
        cyc(1, 1, 5'd11, 3'd0, 64'h0000_0000_0000_000A, 0, "R4");
        idle("R4");
        // R6 + R7: external line 14 under mask
        wr(5'd12, 32'h0000_4001, "R5");
        cyc(0, 0, 0, 0, 0, 7'h40, "R6");
        idle("R6");
        idle("R7");
        cyc(0, 0, 0, 0, 0, 7'h00, "R6");
        idle("R7");
        idle("R7");
        cyc(0, 0, 0, 0, 0, 7'h15, "R6");  // unmasked lines, no request
        idle("R7");
        // R9: ignored writes
        cyc(0, 1, 5'd11, 3'd1, 64'h55, m_hw, "R9");
        cyc(0, 0, 5'd9, 3'd0, 64'h77, m_hw, "R9");
        cyc(0, 1, 5'd9, 3'd2, 64'h88, m_hw, "R9");
        cyc(0, 1, 5'd13, 3'd0, 64'hFFFF_FFFF, m_hw, "R9");
        idle("R9");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule